// File: doc/BRIEF.md
# Scaling-Aware Condition Code Generator

This block keeps the condition code register for a 56-bit accumulator data path. Each cycle it can take a result word with its raw carry and overflow from the arithmetic unit. It can also take a strobe from the data move path saying that saturation took place. Each instruction states, with one enable per flag, which flags it may change. Address arithmetic and plain data transfers leave every enable low, so those flags keep their values.

The extension flag and the unnormalized flag look at a window of the result. That window moves with a 2-bit scaling mode. The limit flag is sticky. Results can set it but never clear it. Only an explicit write that ANDs an immediate mask into the register clears it. The register is eight bits wide, and its top bit always reads as zero.

Top module: `scaled_flag_unit`

## Requirements
- R1: After reset `ccrOut` is 8'h00, and bit 7 of `ccrOut` is 0 at all times.
- R2: The bit layout of `ccrOut` and of `flagEn` is C=0, V=1, Z=2, N=3, U=4, E=5, with L=6 in `ccrOut` only. A flag whose enable bit is 1 in a cycle takes its new value on that clock edge.
- R3: When enabled, N takes bit 55 of `aluResult`, and Z is 1 exactly when all 56 bits of `aluResult` are zero.
- R4: When enabled, C copies `aluCarry` and V copies `aluOverflow`.
- R5: When enabled, E is 0 if the signed integer window of `aluResult` is all zeros or all ones, and 1 otherwise. The window is bits 55..47 for `scaleMode` 2'b00, bits 55..48 for 2'b01 (scale down) and bits 55..46 for 2'b10 (scale up). The reserved code 2'b11 behaves as 2'b00.
- R6: When enabled, U is 1 if two bits of `aluResult` are equal, and 0 otherwise. The pair is 47/46 for `scaleMode` 2'b00, 48/47 for 2'b01 and 46/45 for 2'b10. Code 2'b11 behaves as 2'b00.
- R7: L becomes 1 when `limitHit` is 1, or when the V enable and `aluOverflow` are both 1. Later results never clear it.
- R8: When `andStrobe` is 1, the register becomes its old value ANDed with `andMask`, and bit 7 is forced to 0. In that cycle, every flag enable, `limitHit` and `aluOverflow` is ignored.
- R9: A flag whose enable bit is 0 keeps its value, whatever `aluResult`, `aluCarry`, `aluOverflow` and `scaleMode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aluResult | input | 56 | Accumulator result word |
| aluCarry | input | 1 | Carry or borrow out of bit 55 |
| aluOverflow | input | 1 | 56-bit arithmetic overflow |
| limitHit | input | 1 | Saturation occurred in the data move path |
| scaleMode | input | 2 | 00 none, 01 scale down, 10 scale up, 11 treated as none |
| flagEn | input | 6 | Per-flag update enable, C in bit 0 through E in bit 5 |
| andStrobe | input | 1 | Apply immediate AND to the register |
| andMask | input | 8 | Immediate AND mask |
| ccrOut | output | 8 | Condition code register |

## Verification
The only register between the inputs and the outputs is the flag register itself. Every effect of a stimulus therefore appears on `ccrOut` one rising edge after the inputs are applied. This covers result flags, the limit flag and AND writes alike. The bench changes inputs on the falling edge, waits for exactly one rising edge, and samples a short delay after it. Checks that a value is held, such as a sticky L or a disabled flag, apply a further stimulus and sample after its edge in the same way.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int ACC_W = 56;
  localparam int CCR_W = 8;
  localparam int NUM_RES_FLAGS = 6;

  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_U = 4;
  localparam int BIT_E = 5;
  localparam int BIT_L = 6;

  typedef enum logic [1:0] {
    SCALE_NONE = 2'b00,
    SCALE_DOWN = 2'b01,
    SCALE_UP   = 2'b10,
    SCALE_RSVD = 2'b11
  } scale_e;

  typedef struct packed {
    logic [NUM_RES_FLAGS-1:0] load;
    logic                     setLimit;
    logic                     applyAnd;
  } flag_strobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic [NUM_RES_FLAGS-1:0] flagEn,
  input  logic                     andStrobe,
  input  logic                     limitHit,
  input  logic                     aluOverflow,
  output flag_strobe_t             strobes
);
  always_comb begin
    strobes.applyAnd = andStrobe;
    strobes.load     = andStrobe ? '0 : flagEn;
    strobes.setLimit = !andStrobe && (limitHit || (flagEn[BIT_V] && aluOverflow));
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int RES_W = ACC_W,
  parameter int REG_W = CCR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] aluResult,
  input  logic             aluCarry,
  input  logic             aluOverflow,
  input  logic [1:0]       scaleMode,
  input  logic [REG_W-1:0] andMask,
  input  flag_strobe_t     strobes,
  output logic [REG_W-1:0] ccrQ
);
  localparam int LSB_NONE = RES_W - 9;
  localparam int LSB_DOWN = RES_W - 8;
  localparam int LSB_UP   = RES_W - 10;

  logic [NUM_RES_FLAGS-1:0] newFlags;
  logic [REG_W-1:0]         ccrNext;
  logic                     extUsed;
  logic                     unNorm;
  int                       winLsb;

  always_comb begin
    case (scale_e'(scaleMode))
      SCALE_DOWN: winLsb = LSB_DOWN;
      SCALE_UP:   winLsb = LSB_UP;
      default:    winLsb = LSB_NONE;
    endcase
  end

  always_comb begin
    extUsed = 1'b0;
    for (int i = LSB_UP; i < RES_W - 1; i++) begin
      if (i >= winLsb && aluResult[i] != aluResult[RES_W-1]) extUsed = 1'b1;
    end
    unNorm = (aluResult[winLsb] == aluResult[winLsb-1]);
  end

  always_comb begin
    newFlags        = '0;
    newFlags[BIT_C] = aluCarry;
    newFlags[BIT_V] = aluOverflow;
    newFlags[BIT_Z] = (aluResult == '0);
    newFlags[BIT_N] = aluResult[RES_W-1];
    newFlags[BIT_U] = unNorm;
    newFlags[BIT_E] = extUsed;
  end

  always_comb begin
    ccrNext = ccrQ;
    if (strobes.applyAnd) begin
      ccrNext = ccrQ & andMask;
    end else begin
      for (int f = 0; f < NUM_RES_FLAGS; f++) begin
        if (strobes.load[f]) ccrNext[f] = newFlags[f];
      end
      ccrNext[BIT_L] = ccrQ[BIT_L] | strobes.setLimit;
    end
    ccrNext[REG_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ccrQ <= '0;
    else       ccrQ <= ccrNext;
  end

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ccrQ[REG_W-1] == 1'b0); // R1
  AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[BIT_N] |=> ccrQ[BIT_N] == $past(aluResult[RES_W-1])); // R3
  AST_L_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ccrQ[BIT_L] && !strobes.applyAnd) |=> ccrQ[BIT_L]); // R7
  AST_AND_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.applyAnd |=> (ccrQ & ~$past(andMask)) == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load == '0 && !strobes.setLimit && !strobes.applyAnd) |=> $stable(ccrQ)); // R9
endmodule

// File: rtl/scaled_flag_unit.sv
module scaled_flag_unit
  import flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [55:0] aluResult,
  input  logic        aluCarry,
  input  logic        aluOverflow,
  input  logic        limitHit,
  input  logic [1:0]  scaleMode,
  input  logic [5:0]  flagEn,
  input  logic        andStrobe,
  input  logic [7:0]  andMask,
  output logic [7:0]  ccrOut
);
  flag_strobe_t strobes;

  flag_ctrl i_ctrl (
    .flagEn      (flagEn),
    .andStrobe   (andStrobe),
    .limitHit    (limitHit),
    .aluOverflow (aluOverflow),
    .strobes     (strobes)
  );

  flag_datapath #(.RES_W(ACC_W), .REG_W(CCR_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .aluResult   (aluResult),
    .aluCarry    (aluCarry),
    .aluOverflow (aluOverflow),
    .scaleMode   (scaleMode),
    .andMask     (andMask),
    .strobes     (strobes),
    .ccrQ        (ccrOut)
  );
endmodule

// File: tb/test_scaled_flag_unit.sv
`timescale 1ns/1ps
module test_scaled_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [55:0] aluResult = '0;
  logic        aluCarry = 1'b0;
  logic        aluOverflow = 1'b0;
  logic        limitHit = 1'b0;
  logic [1:0]  scaleMode = 2'b00;
  logic [5:0]  flagEn = '0;
  logic        andStrobe = 1'b0;
  logic [7:0]  andMask = '0;
  logic [7:0]  ccrOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scaled_flag_unit i_scaled_flag_unit (
    .clk(clk), .rstN(rstN), .aluResult(aluResult), .aluCarry(aluCarry),
    .aluOverflow(aluOverflow), .limitHit(limitHit), .scaleMode(scaleMode),
    .flagEn(flagEn), .andStrobe(andStrobe), .andMask(andMask), .ccrOut(ccrOut)
  );

  function automatic logic expE(input logic [55:0] r, input logic [1:0] m);
    logic [9:0] w;
    case (m)
      2'b01:   w = {{2{r[55]}}, r[55:48]};
      2'b10:   w = r[55:46];
      default: w = {r[55], r[55:47]};
    endcase
    return !((w == '0) || (w == '1));
  endfunction

  function automatic logic expU(input logic [55:0] r, input logic [1:0] m);
    case (m)
      2'b01:   return r[48] == r[47];
      2'b10:   return r[46] == r[45];
      default: return r[47] == r[46];
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (ccrOut !== exp) begin
      bad++;
      $display("FAIL %s: ccrOut=%h expected=%h", req, ccrOut, exp);
    end
  endtask

  // Apply inputs on a falling edge, let one rising edge pass, sample after it.
  task automatic step(input logic [55:0] r, input logic c, input logic v,
                      input logic lim, input logic [1:0] m, input logic [5:0] en,
                      input logic andS, input logic [7:0] msk);
    @(negedge clk);
    aluResult = r; aluCarry = c; aluOverflow = v; limitHit = lim;
    scaleMode = m; flagEn = en; andStrobe = andS; andMask = msk;
    @(posedge clk);
    #1;
    @(negedge clk);
    flagEn = '0; limitHit = 1'b0; andStrobe = 1'b0;
  endtask

  task automatic clearAll();
    step('0, 0, 0, 0, 2'b00, 6'h00, 1'b1, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 reset", 8'h00);
  endtask

  task automatic t_nz();
    step('0, 0, 0, 0, 2'b00, 6'h3F, 0, 8'h00);
    check("R3 zero result", 8'h14);
    step(56'h80_0000_0000_0000, 0, 0, 0, 2'b00, 6'h3F, 0, 8'h00);
    check("R3 negative", 8'h38);
  endtask

  task automatic t_cv();
    clearAll();
    step(56'h1, 1, 0, 0, 2'b00, 6'h3F, 0, 8'h00);
    check("R4 carry", 8'h11);
    step(56'h1, 1, 1, 0, 2'b00, 6'h3F, 0, 8'h00);
    check("R4 overflow sets V and R7 L", 8'h53);
  endtask

  task automatic t_scaling();
    logic [55:0] pats [4];
    pats[0] = 56'h00_8000_0000_0000;
    pats[1] = 56'h00_4000_0000_0000;
    pats[2] = 56'h00_2000_0000_0000;
    pats[3] = 56'hFF_0000_0000_0000;
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        clearAll();
        step(pats[p], 0, 0, 0, 2'(m), 6'h30, 0, 8'h00);
        check("R5 R6 E/U window", {2'b00, expE(pats[p], 2'(m)), expU(pats[p], 2'(m)), 4'h0});
      end
    end
  endtask

  task automatic t_sticky();
    clearAll();
    step('0, 0, 0, 1, 2'b00, 6'h00, 0, 8'h00);
    check("R7 limitHit alone", 8'h40);
    step(56'h12_3456, 0, 0, 0, 2'b00, 6'h3F, 0, 8'h00);
    check("R7 L survives result", 8'h50);
    step(56'h1, 0, 1, 0, 2'b00, 6'h3D, 0, 8'h00);
    check("R7 overflow without V enable", 8'h50);
  endtask

  task automatic t_and();
    clearAll();
    step(56'h1, 1, 1, 0, 2'b00, 6'h3F, 0, 8'h00);
    step('0, 0, 0, 0, 2'b00, 6'h00, 1, 8'hBF);
    check("R8 clear L only", 8'h13);
    step('0, 1, 1, 1, 2'b00, 6'h3F, 1, 8'hFE);
    check("R8 AND wins over updates", 8'h12);
    step('0, 0, 0, 0, 2'b00, 6'h00, 1, 8'hFF);
    check("R1 R8 bit7 stays zero", 8'h12);
    step('0, 0, 0, 0, 2'b00, 6'h00, 1, 8'h00);
    check("R8 clear all", 8'h00);
  endtask

  task automatic t_hold();
    clearAll();
    step(56'h80_0000_0000_0000, 1, 0, 0, 2'b00, 6'h3F, 0, 8'h00);
    step('0, 0, 1, 0, 2'b10, 6'h00, 0, 8'h00);
    check("R9 no enables hold", 8'h39);
    step('0, 0, 0, 0, 2'b00, 6'h04, 0, 8'h00);
    check("R2 R9 only Z updates", 8'h3D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_nz();
    t_cv();
    t_scaling();
    t_sticky();
    t_and();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule